// File: doc/BRIEF.md
# DDR Quad-I/O Flash Read Sequencer

This block is the host end of a fast read from a serial NOR flash. It uses one chip select, a serial clock and four data lines. When a request arrives, it lowers chip select. It then sends an 8-bit opcode one bit per serial clock on line 0. After that it sends the 32-bit start address, then a mode byte, with a nibble on every serial clock edge. It then releases all four lines for a dummy window. Once the dummy window ends, it assembles one byte per serial clock from the nibbles that the flash returns on both edges.

The serial clock runs at half the system clock rate, so each system clock cycle is one half of a serial clock period. The mode byte can request continuous mode. In that case the next access starts directly with the address and sends no opcode. The flash may place a known 8-bit training pattern on every line during the last four dummy cycles. When checking is enabled, the block compares each line against the expected pattern and keeps a sticky error flag on a mismatch. Read data is delivered as a byte stream, and a one-cycle done pulse marks the end of each request.

Top module: `qrd_ddr_reader`

## Requirements
- R1: After reset, and whenever no read is in progress, `cs_n` is high, `sclk` is low, `io_oe` is 0 and `req_ready` is high.
- R2: When continuous mode is not in force, chip select falls and the first 8 serial clocks carry the opcode (default 8'hEE), most significant bit first. The opcode is on line 0 only, with `io_oe` = 4'b0001.
- R3: The 32-bit start address takes 4 serial clocks, one nibble per edge, most significant nibble first. Line 3 carries the top bit of each nibble, and `io_oe` is 4'hF.
- R4: The mode byte takes one serial clock, high nibble on the first edge. Its value is 8'hA0 when `req_keep_cont` is 1 and 8'h00 otherwise.
- R5: If the previous access sent mode byte 8'hA0, the next access begins with the address and sends no opcode. After an access that sent 8'h00, the next access sends the opcode again.
- R6: `io_oe` is 0 from the first dummy half-cycle until chip select rises. The dummy window lasts 7 serial clocks.
- R7: Read data is one byte per serial clock. On the first edge, lines 3..0 carry bits 7..4; on the second edge they carry bits 3..0. Each byte appears on `rd_data` with `rd_valid` high for one cycle, in the cycle after its second half. Bytes come from consecutive addresses, and the address wraps past 32'hFFFFFFFF.
- R8: After `req_len` bytes, chip select rises and `done` is high for exactly one cycle. This is cycle T after acceptance, where T = 16 (if the opcode is sent) + 24 + 2·`req_len`. While a read is in progress `req_ready` is low, and a request raised then is ignored.
- R9: With `req_dlp_en` high, each line is compared during the last 4 dummy serial clocks against pattern 8'h34, one bit per edge, most significant bit first. Any mismatch sets `dlp_err` in the following cycle. The flag stays set until the next request is accepted. Data capture is unaffected.
- R10: With `req_dlp_en` low, pattern mismatches do not set `dlp_err`. Accepting a request clears the flag.
- R11: While chip select is low, `sclk` toggles every system clock cycle. It starts low in the first cycle after chip select falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; two cycles make one serial clock period |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Sequencer idle; a request is taken when both are high |
| req_addr | input | 32 | Start byte address |
| req_len | input | 16 | Byte count; 0 is not accepted |
| req_keep_cont | input | 1 | Send the continuous-mode byte for this access |
| req_dlp_en | input | 1 | Check the training pattern in the dummy window |
| cs_n | output | 1 | Flash chip select, active low |
| sclk | output | 1 | Serial clock |
| io_out | output | 4 | Values driven onto the four data lines |
| io_oe | output | 4 | Per-line output enable |
| io_in | input | 4 | Values read from the four data lines |
| rd_data | output | 8 | Captured read byte |
| rd_valid | output | 1 | `rd_data` holds a new byte |
| done | output | 1 | One-cycle pulse when a read completes |
| dlp_err | output | 1 | Sticky training-pattern mismatch flag |

## Verification
The hardest situations to reach are those that depend on history. Whether an access skips its opcode depends only on the mode byte of the previous access. The error flag depends on a single bit on a single line during one dummy half-cycle. The bench therefore chains directed reads in a fixed order, so that continue, exit and continue again each follow a known predecessor. Its flash model counts half-cycles from the fall of chip select. It decodes its own continuous-mode state from the mode byte it received. It also inverts line 2 in exactly one pattern half when asked. That corrupted pattern is sent once with checking enabled and once with it disabled, and in both cases the data stream is compared byte for byte.

// File: rtl/qrd_pkg.sv
package qrd_pkg;

    localparam int QRD_ADDR_W = 32;
    localparam int QRD_LEN_W  = 16;
    localparam int QRD_LANES  = 4;
    localparam int QRD_NIB_W  = 4;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_CMD,
        PH_ADDR,
        PH_MODE,
        PH_DUMMY,
        PH_DATA,
        PH_DONE
    } qrd_phase_e;

    typedef struct packed {
        logic [QRD_ADDR_W-1:0] addr;
        logic                  keep_cont;
        logic                  dlp_en;
    } qrd_req_t;

    // Nibble idx of a word, counted from the most significant end.
    function automatic logic [QRD_NIB_W-1:0] qrd_addr_nibble(
        input logic [QRD_ADDR_W-1:0] word,
        input int                    idx
    );
        logic [QRD_ADDR_W-1:0] shifted;
        shifted = word >> (QRD_ADDR_W - QRD_NIB_W - QRD_NIB_W * idx);
        return shifted[QRD_NIB_W-1:0];
    endfunction

    function automatic int qrd_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic logic qrd_chip_selected(input qrd_phase_e ph);
        return (ph != PH_IDLE) && (ph != PH_DONE);
    endfunction

endpackage

// File: rtl/qrd_seq.sv
module qrd_seq
    import qrd_pkg::*;
#(
    parameter int CMD_HALVES   = 16,
    parameter int ADDR_HALVES  = 8,
    parameter int MODE_HALVES  = 2,
    parameter int DUMMY_HALVES = 14,
    parameter int CNT_W        = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic                 skip_cmd,
    input  logic [QRD_LEN_W-1:0] len,
    output qrd_phase_e           phase,
    output logic [CNT_W-1:0]     hcnt
);

    logic [QRD_LEN_W-1:0] rem_q;
    logic                 at_end;

    always_comb begin
        case (phase)
            PH_CMD:   at_end = (hcnt == CNT_W'(CMD_HALVES - 1));
            PH_ADDR:  at_end = (hcnt == CNT_W'(ADDR_HALVES - 1));
            PH_MODE:  at_end = (hcnt == CNT_W'(MODE_HALVES - 1));
            PH_DUMMY: at_end = (hcnt == CNT_W'(DUMMY_HALVES - 1));
            PH_DATA:  at_end = hcnt[0];
            default:  at_end = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            hcnt  <= '0;
            rem_q <= '0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    hcnt <= '0;
                    if (start) begin
                        phase <= skip_cmd ? PH_ADDR : PH_CMD;
                        rem_q <= len;
                    end
                end
                PH_CMD: begin
                    if (at_end) begin
                        phase <= PH_ADDR;
                        hcnt  <= '0;
                    end else begin
                        hcnt <= hcnt + CNT_W'(1);
                    end
                end
                PH_ADDR: begin
                    if (at_end) begin
                        phase <= PH_MODE;
                        hcnt  <= '0;
                    end else begin
                        hcnt <= hcnt + CNT_W'(1);
                    end
                end
                PH_MODE: begin
                    if (at_end) begin
                        phase <= PH_DUMMY;
                        hcnt  <= '0;
                    end else begin
                        hcnt <= hcnt + CNT_W'(1);
                    end
                end
                PH_DUMMY: begin
                    if (at_end) begin
                        phase <= PH_DATA;
                        hcnt  <= '0;
                    end else begin
                        hcnt <= hcnt + CNT_W'(1);
                    end
                end
                PH_DATA: begin
                    if (at_end) begin
                        hcnt <= '0;
                        if (rem_q == QRD_LEN_W'(1)) begin
                            phase <= PH_DONE;
                        end else begin
                            rem_q <= rem_q - QRD_LEN_W'(1);
                        end
                    end else begin
                        hcnt <= hcnt + CNT_W'(1);
                    end
                end
                PH_DONE: begin
                    phase <= PH_IDLE;
                    hcnt  <= '0;
                end
                default: begin
                    phase <= PH_IDLE;
                    hcnt  <= '0;
                end
            endcase
        end
    end

endmodule

// File: rtl/qrd_tx.sv
module qrd_tx
    import qrd_pkg::*;
#(
    parameter logic [7:0] OPCODE = 8'hEE,
    parameter int         CNT_W  = 4
) (
    input  qrd_phase_e            phase,
    input  logic [CNT_W-1:0]      hcnt,
    input  logic [QRD_ADDR_W-1:0] addr,
    input  logic [7:0]            mode,
    output logic [QRD_LANES-1:0]  io_out,
    output logic [QRD_LANES-1:0]  io_oe
);

    // Opcode bits hold for a whole serial clock (two half-cycles).
    logic [2:0] bit_idx;
    assign bit_idx = 3'(hcnt >> 1);

    always_comb begin
        io_out = '0;
        io_oe  = '0;
        case (phase)
            PH_CMD: begin
                io_out[0] = OPCODE[3'd7 - bit_idx];
                io_oe     = QRD_LANES'(1);
            end
            PH_ADDR: begin
                io_out = qrd_addr_nibble(addr, int'(hcnt));
                io_oe  = '1;
            end
            PH_MODE: begin
                io_out = hcnt[0] ? mode[3:0] : mode[7:4];
                io_oe  = '1;
            end
            default: begin
                io_out = '0;
                io_oe  = '0;
            end
        endcase
    end

endmodule

// File: rtl/qrd_rx.sv
module qrd_rx
    import qrd_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_data,
    input  logic                 second_half,
    input  logic [QRD_LANES-1:0] io_in,
    output logic [7:0]           rd_data,
    output logic                 rd_valid
);

    logic [QRD_LANES-1:0] hi_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q     <= '0;
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= in_data && second_half;
            if (in_data && !second_half) begin
                hi_q <= io_in;
            end
            if (in_data && second_half) begin
                rd_data <= {hi_q, io_in};
            end
        end
    end

endmodule

// File: rtl/qrd_dlp.sv
module qrd_dlp
    import qrd_pkg::*;
#(
    parameter logic [7:0] PATTERN   = 8'h34,
    parameter int         WIN_START = 6,
    parameter int         CNT_W     = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 enable,
    input  logic                 in_dummy,
    input  logic                 clear,
    input  logic [CNT_W-1:0]     hcnt,
    input  logic [QRD_LANES-1:0] io_in,
    output logic                 err
);

    logic                 in_win;
    logic [CNT_W-1:0]     rel;
    logic                 exp_bit;
    logic [QRD_LANES-1:0] miss;

    assign in_win  = enable && in_dummy && (hcnt >= CNT_W'(WIN_START));
    assign rel     = hcnt - CNT_W'(WIN_START);
    assign exp_bit = PATTERN[3'd7 - 3'(rel)];

    for (genvar k = 0; k < QRD_LANES; k++) begin : g_lane
        assign miss[k] = in_win && (io_in[k] != exp_bit);
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            err <= 1'b0;
        end else if (|miss) begin
            err <= 1'b1;
        end
    end

endmodule

// File: rtl/qrd_ddr_reader.sv
module qrd_ddr_reader
    import qrd_pkg::*;
#(
    parameter logic [7:0] OPCODE      = 8'hEE,
    parameter logic [7:0] MODE_CONT   = 8'hA0,
    parameter logic [7:0] MODE_EXIT   = 8'h00,
    parameter int         DUMMY_CYC   = 7,
    parameter logic [7:0] DLP_PATTERN = 8'h34
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic [QRD_ADDR_W-1:0] req_addr,
    input  logic [QRD_LEN_W-1:0]  req_len,
    input  logic                  req_keep_cont,
    input  logic                  req_dlp_en,
    output logic                  cs_n,
    output logic                  sclk,
    output logic [QRD_LANES-1:0]  io_out,
    output logic [QRD_LANES-1:0]  io_oe,
    input  logic [QRD_LANES-1:0]  io_in,
    output logic [7:0]            rd_data,
    output logic                  rd_valid,
    output logic                  done,
    output logic                  dlp_err
);

    localparam int CMD_HALVES   = 2 * 8;
    localparam int ADDR_HALVES  = QRD_ADDR_W / QRD_NIB_W;
    localparam int MODE_HALVES  = 2;
    localparam int DUMMY_HALVES = 2 * DUMMY_CYC;
    localparam int DLP_HALVES   = 8;
    localparam int DLP_START    = DUMMY_HALVES - DLP_HALVES;
    localparam int MAX_HALVES   = qrd_max(qrd_max(CMD_HALVES, ADDR_HALVES), DUMMY_HALVES);
    localparam int CNT_W        = $clog2(MAX_HALVES);

    qrd_phase_e       phase;
    logic [CNT_W-1:0] hcnt;
    qrd_req_t         req_q;
    logic             cont_q;
    logic             accept;
    logic [7:0]       mode_byte;

    assign req_ready = (phase == PH_IDLE);
    assign accept    = req_valid && req_ready && (req_len != '0);
    assign mode_byte = req_q.keep_cont ? MODE_CONT : MODE_EXIT;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q  <= '0;
            cont_q <= 1'b0;
        end else begin
            if (accept) begin
                req_q.addr      <= req_addr;
                req_q.keep_cont <= req_keep_cont;
                req_q.dlp_en    <= req_dlp_en;
            end
            if (phase == PH_DONE) begin
                cont_q <= req_q.keep_cont;
            end
        end
    end

    qrd_seq #(
        .CMD_HALVES  (CMD_HALVES),
        .ADDR_HALVES (ADDR_HALVES),
        .MODE_HALVES (MODE_HALVES),
        .DUMMY_HALVES(DUMMY_HALVES),
        .CNT_W       (CNT_W)
    ) u_seq (
        .clk     (clk),
        .rst     (rst),
        .start   (accept),
        .skip_cmd(cont_q),
        .len     (req_len),
        .phase   (phase),
        .hcnt    (hcnt)
    );

    qrd_tx #(
        .OPCODE(OPCODE),
        .CNT_W (CNT_W)
    ) u_tx (
        .phase (phase),
        .hcnt  (hcnt),
        .addr  (req_q.addr),
        .mode  (mode_byte),
        .io_out(io_out),
        .io_oe (io_oe)
    );

    qrd_rx u_rx (
        .clk        (clk),
        .rst        (rst),
        .in_data    (phase == PH_DATA),
        .second_half(hcnt[0]),
        .io_in      (io_in),
        .rd_data    (rd_data),
        .rd_valid   (rd_valid)
    );

    qrd_dlp #(
        .PATTERN  (DLP_PATTERN),
        .WIN_START(DLP_START),
        .CNT_W    (CNT_W)
    ) u_dlp (
        .clk     (clk),
        .rst     (rst),
        .enable  (req_q.dlp_en),
        .in_dummy(phase == PH_DUMMY),
        .clear   (accept),
        .hcnt    (hcnt),
        .io_in   (io_in),
        .err     (dlp_err)
    );

    assign cs_n = !qrd_chip_selected(phase);
    assign sclk = !cs_n && hcnt[0];
    assign done = (phase == PH_DONE);

endmodule

// File: rtl/qrd_ddr_reader_chk.sv
module qrd_ddr_reader_chk (
    input logic       clk,
    input logic       rst,
    input logic       cs_n,
    input logic       sclk,
    input logic [3:0] io_oe,
    input logic       done,
    input logic       req_valid,
    input logic       req_ready,
    input logic       rd_valid,
    input logic       dlp_err
);

    p_idle_lines_r1: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> (!sclk && io_oe == 4'h0));

    p_sclk_toggle_r11: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && $past(!cs_n)) |-> (sclk != $past(sclk)));

    p_sclk_starts_low_r11: assert property (@(posedge clk) disable iff (rst)
        $fell(cs_n) |-> !sclk);

    p_bus_released_r6: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && $past(!cs_n) && io_oe == 4'h0) |=> (cs_n || io_oe == 4'h0));

    p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_done_deselect_r8: assert property (@(posedge clk) disable iff (rst)
        done |-> cs_n);

    p_busy_not_ready_r8: assert property (@(posedge clk) disable iff (rst)
        !cs_n |-> !req_ready);

    p_byte_while_busy_r7: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> !req_ready);

    p_err_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        (dlp_err && !(req_valid && req_ready)) |=> dlp_err);

endmodule

bind qrd_ddr_reader qrd_ddr_reader_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .cs_n     (cs_n),
    .sclk     (sclk),
    .io_oe    (io_oe),
    .done     (done),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .rd_valid (rd_valid),
    .dlp_err  (dlp_err)
);

// File: tb/qrd_ddr_reader_tb.sv
module qrd_ddr_reader_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic [15:0] req_len = '0;
    logic        req_keep_cont = 1'b0;
    logic        req_dlp_en = 1'b0;
    logic        cs_n;
    logic        sclk;
    logic [3:0]  io_out;
    logic [3:0]  io_oe;
    logic [3:0]  io_in;
    logic [7:0]  rd_data;
    logic        rd_valid;
    logic        done;
    logic        dlp_err;

    always #2 clk = ~clk;

    qrd_ddr_reader u_dut (
        .clk          (clk),
        .rst          (rst),
        .req_valid    (req_valid),
        .req_ready    (req_ready),
        .req_addr     (req_addr),
        .req_len      (req_len),
        .req_keep_cont(req_keep_cont),
        .req_dlp_en   (req_dlp_en),
        .cs_n         (cs_n),
        .sclk         (sclk),
        .io_out       (io_out),
        .io_oe        (io_oe),
        .io_in        (io_in),
        .rd_data      (rd_data),
        .rd_valid     (rd_valid),
        .done         (done),
        .dlp_err      (dlp_err)
    );

    int n_checks = 0;
    int n_errors = 0;
    bit exp_cont = 1'b0;

    // Flash model: counts half-cycles from the fall of chip select.
    bit          in_txn = 1'b0;
    int          n = 0;
    bit          m_cont = 1'b0;
    bit          m_had_cmd = 1'b0;
    logic [7:0]  m_op = '0;
    logic [31:0] m_addr = '0;
    logic [7:0]  m_mode = '0;
    int          m_bad_oe = 0;
    int          m_bad_sclk = 0;
    bit          m_corrupt = 1'b0;
    logic [7:0]  m_pat = 8'h34;
    logic [3:0]  io_in_r = '0;

    assign io_in = io_in_r;

    function automatic logic [7:0] mem_byte(input logic [31:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h3C;
    endfunction

    always @(negedge clk) begin : flash_model
        int         pre;
        int         d;
        int         j;
        logic       b;
        logic [7:0] byt;
        if (!cs_n) begin
            if (!in_txn) begin
                in_txn    = 1'b1;
                n         = 0;
                m_had_cmd = !m_cont;
                m_op      = '0;
                m_addr    = '0;
                m_mode    = '0;
            end
            pre = m_had_cmd ? 16 : 0;
            if (sclk !== n[0]) m_bad_sclk++;
            io_in_r = 4'h0;
            if (n < pre) begin
                if (io_oe !== 4'b0001) m_bad_oe++;
                if (n[0] == 1'b0) m_op = {m_op[6:0], io_out[0]};
            end else if (n < pre + 8) begin
                if (io_oe !== 4'hF) m_bad_oe++;
                m_addr = {m_addr[27:0], io_out};
            end else if (n < pre + 10) begin
                if (io_oe !== 4'hF) m_bad_oe++;
                m_mode = {m_mode[3:0], io_out};
            end else begin
                if (io_oe !== 4'h0) m_bad_oe++;
                d = n - pre - 10;
                if (d < 14) begin
                    if (d >= 6) begin
                        b = m_pat[7-(d-6)];
                        io_in_r = {4{b}};
                        if (m_corrupt && d == 9) io_in_r[2] = ~b;
                    end
                end else begin
                    j   = (d - 14) / 2;
                    byt = mem_byte(m_addr + 32'(j));
                    io_in_r = (((d - 14) % 2) == 0) ? byt[7:4] : byt[3:0];
                end
            end
            n++;
        end else if (in_txn) begin
            in_txn = 1'b0;
            m_cont = (m_mode[7:4] == 4'hA);
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic check_reset_state();
        check(cs_n === 1'b1, "R1", "cs_n idle", cs_n, 1);
        check(sclk === 1'b0, "R1", "sclk idle", sclk, 0);
        check(io_oe === 4'h0, "R1", "io_oe idle", io_oe, 0);
        check(req_ready === 1'b1, "R1", "req_ready idle", req_ready, 1);
        check(done === 1'b0 && rd_valid === 1'b0, "R8", "no done or byte at idle",
              {done, rd_valid}, 0);
        check(dlp_err === 1'b0, "R9", "error flag after reset", dlp_err, 0);
    endtask

    // One read from request to the cycle after done.
    task automatic run_read(input logic [31:0] a, input int len, input bit keep,
                            input bit dlp, input bit corrupt, input bit poke,
                            input bit exp_err);
        bit exp_cmd;
        int pre;
        int total;
        int got;
        int done_k;
        int bad_data;
        int bad_time;
        int ready_bad;
        bit err_seen;
        exp_cmd   = !exp_cont;
        pre       = (exp_cmd ? 16 : 0) + 24;
        total     = pre + 2 * len;
        got       = 0;
        done_k    = -1;
        bad_data  = 0;
        bad_time  = 0;
        ready_bad = 0;
        err_seen  = 1'b0;
        m_bad_oe   = 0;
        m_bad_sclk = 0;
        @(posedge clk); #1;
        m_corrupt     = corrupt;
        req_valid     = 1'b1;
        req_addr      = a;
        req_len       = 16'(len);
        req_keep_cont = keep;
        req_dlp_en    = dlp;
        @(posedge clk); #1;
        req_valid = 1'b0;
        for (int k = 1; k <= total + 4 && done_k < 0; k++) begin
            if (poke && k == 6) begin
                req_valid = 1'b1;
                req_addr  = ~a;
            end
            if (poke && k == 7) req_valid = 1'b0;
            @(posedge clk); #1;
            if (k < total && req_ready) ready_bad++;
            if (dlp_err) err_seen = 1'b1;
            if (rd_valid) begin
                if (rd_data !== mem_byte(a + 32'(got))) begin
                    bad_data++;
                    $display("FAIL R7 byte %0d: actual=%0h expected=%0h",
                             got, rd_data, mem_byte(a + 32'(got)));
                end
                if (k != pre + 2 * got + 2) bad_time++;
                got++;
            end
            if (done) begin
                done_k = k;
                check(cs_n === 1'b1, "R8", "chip select high at done", cs_n, 1);
            end
        end
        check(done_k == total, "R8", "done cycle", done_k, total);
        check(got == len, "R7", "byte count", got, len);
        check(bad_data == 0, "R7", "byte values", bad_data, 0);
        check(bad_time == 0, "R7", "byte timing", bad_time, 0);
        check(err_seen == exp_err, "R9", "error flag during read", err_seen, exp_err);
        check(dlp_err === exp_err, "R10", "error flag at done", dlp_err, exp_err);
        if (poke) begin
            check(ready_bad == 0, "R8", "ready low while busy", ready_bad, 0);
        end
        @(posedge clk); #1;
        check(done === 1'b0, "R8", "done lasts one cycle", done, 0);
        check(m_had_cmd == exp_cmd, "R5", "opcode phase present", m_had_cmd, exp_cmd);
        if (exp_cmd) check(m_op == 8'hEE, "R2", "opcode", m_op, 8'hEE);
        check(m_addr == a, "R3", "address sent", m_addr, a);
        check(m_mode == (keep ? 8'hA0 : 8'h00), "R4", "mode byte", m_mode,
              keep ? 8'hA0 : 8'h00);
        check(m_bad_oe == 0, "R6", "line enables per phase", m_bad_oe, 0);
        check(m_bad_sclk == 0, "R11", "serial clock phase", m_bad_sclk, 0);
        check(dlp_err === exp_err, "R9", "flag held after done", dlp_err, exp_err);
        check_reset_state_idle();
        exp_cont = keep;
    endtask

    task automatic check_reset_state_idle();
        check(cs_n === 1'b1 && io_oe === 4'h0 && req_ready === 1'b1, "R1",
              "idle after read", {cs_n, io_oe, req_ready}, 6'h21);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL R8 watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin : main
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        check_reset_state();
        // R2 R3 R4 R8: full read with opcode, keep continuous, busy poke.
        run_read(32'h1234_5678, 4, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
        // R5: continuous access without opcode, then exit.
        run_read(32'h0000_FFFE, 3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        // R5 R7 R9: opcode again, address wrap, good pattern checked.
        run_read(32'hFFFF_FFFF, 2, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        // R9: corrupted pattern with checking on.
        run_read(32'h0000_0100, 2, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1);
        // R10: corrupted pattern with checking off; flag cleared on accept.
        run_read(32'h0000_0200, 1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        // R5: after exit the opcode returns.
        run_read(32'h0000_0300, 2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        finish_run();
    end

endmodule